// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control logic in a small processor core that hands control from the running program to an interrupt handler, and later gives control back. It watches a set of device request lines. It acts on them only when the execution unit reports that an instruction has finished. When it takes a request, it pulses an acknowledge back to the one device it chose. It then pushes the return address and the status word onto a downward-growing stack in memory. Finally it loads the program counter with that source's handler entry address and redirects fetch.

A return strobe reverses the process. The sequencer pops the status word and then the return address, and loads both into the core. It stalls instruction fetch through its busy output whenever it is not idle. The status word carries an interrupt-enable bit. That bit is cleared on entry and comes back when the saved word is restored, so handlers do not nest unless software re-enables interrupts itself.

The stack port is a plain single-cycle memory port with no back-pressure. A write commits at the clock edge in which the write strobe is high. Read data must be returned combinationally in the same cycle as the read strobe. Control pins are plain levels or single-cycle pulses.

Top module: `irq_seq`

## Requirements
- R1: A request is taken only in an idle cycle where `instr_done` is high, `iret` is low, and bit `IE_BIT` (default 7) of `psw_in` is 1. No acknowledge occurs in any other case, including while a request is held with `instr_done` low.
- R2: After an accepting clock edge, `irq_ack` is one-hot on the chosen source for exactly the next cycle, and is zero otherwise.
- R3: When several lines are requesting, the lowest-numbered line wins.
- R4: Entry pushes two words, one per cycle, with the stack pointer decremented before each write. The first word is the return address, written at SP-1. The second is the status word, written at SP-2. Afterwards `sp` equals the old value minus 2. Read and write strobes are never high together.
- R5: The return address that is saved is the `next_pc` value present at the accepting edge, and the status word saved is the `psw_in` value present at that edge.
- R6: In the cycle after the second push, `pc_load`, `psw_load` and `fetch_redirect` are high together. `pc_load_val` is the chosen source's vector. `psw_load_val` is the saved status word with bit `IE_BIT` cleared.
- R7: A return pops the status word from address SP and then the return address from SP+1, one per cycle. In the second cycle it loads both with `fetch_redirect` high. Afterwards `sp` equals the old value plus 2.
- R8: `busy` is high in every non-idle cycle: four cycles for entry and two for return. It drops in the cycle after `fetch_redirect`.
- R9: Vector entry i resets to `VEC_BASE + i*VEC_STRIDE` (defaults 0x0100 and 0x0010). A cycle with `vec_we` high replaces entry `vec_sel` with `vec_wdata`.
- R10: When `iret` and an acceptable request are present in the same idle cycle, the return is performed and no acknowledge is given.
- R11: A request that arrives while interrupts are disabled stays pending as long as the device holds its line. It is taken at the first later boundary where interrupts are enabled.
- R12: After reset `busy`, `irq_ack` and all load, redirect and stack strobes are low, and `sp` equals `SP_RESET` (default 0xF0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Device request lines, held until acknowledged |
| instr_done | input | 1 | Current instruction has completed |
| iret | input | 1 | Return-from-handler strobe |
| next_pc | input | DW | Address of the next sequential instruction |
| psw_in | input | DW | Current status word |
| vec_we | input | 1 | Write strobe for the vector bank |
| vec_sel | input | SRCW | Vector entry selected for writing |
| vec_wdata | input | DW | New handler entry address |
| irq_ack | output | NSRC | One-cycle acknowledge to the chosen device |
| stk_we | output | 1 | Stack memory write strobe |
| stk_re | output | 1 | Stack memory read strobe |
| stk_addr | output | SPW | Stack memory address |
| stk_wdata | output | DW | Stack memory write data |
| stk_rdata | input | DW | Stack memory read data, same cycle |
| sp | output | SPW | Current stack pointer |
| pc_load | output | 1 | Load program counter |
| pc_load_val | output | DW | Value to load into the program counter |
| psw_load | output | 1 | Load status word |
| psw_load_val | output | DW | Value to load into the status word |
| fetch_redirect | output | 1 | Restart fetch from the newly loaded PC |
| busy | output | 1 | Sequencer active; stalls fetch |

## Verification
A wrong state in the sequencer shows up within one cycle at the ports. It can appear as an acknowledge on the wrong line, a stack address off by one, or a strobe in the wrong cycle. A stack pointer that drifts, or a saved word latched at the wrong edge, may stay hidden on entry and then show up at the next return. There the popped return address or status word will not match what was pushed. Because of this, every entry is followed by a return, and both the stack address and `sp` are compared in each cycle of each sequence. Priority and masking faults show up as an acknowledge on a different line, or an acknowledge at a boundary that should have been ignored.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_PUSH_PC,
    ST_PUSH_PSW,
    ST_VECTOR,
    ST_POP_PSW,
    ST_POP_PC
  } seq_state_e;

  typedef enum logic [1:0] {
    SP_HOLD,
    SP_DEC,
    SP_INC
  } sp_op_e;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  assign any = |req;

  always_comb begin
    AST_GNT_LOWEST: assert (((gnt - N'(1)) & req) == '0 || gnt == '0); // R3
  end

endmodule

// File: rtl/irq_vec_bank.sv
module irq_vec_bank #(
  parameter int N = 4,
  parameter int DW = 16,
  parameter logic [DW-1:0] VEC_BASE = 16'h0100,
  parameter int VEC_STRIDE = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] rsel,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] vec_q [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    localparam logic [DW-1:0] RST_VAL = VEC_BASE + DW'(g * VEC_STRIDE);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[g] <= RST_VAL;
      end else if (we && wsel == IW'(g)) begin
        vec_q[g] <= wdata;
      end
    end
  end

  assign rdata = vec_q[rsel];

endmodule

// File: rtl/irq_stack_ptr.sv
module irq_stack_ptr
  import irq_seq_pkg::*;
#(
  parameter int SPW = 8,
  parameter logic [SPW-1:0] SP_RESET = 8'hF0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  sp_op_e         op,
  output logic [SPW-1:0] sp,
  output logic [SPW-1:0] sp_dec
);

  assign sp_dec = sp - SPW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= SP_RESET;
    end else begin
      unique case (op)
        SP_DEC:  sp <= sp_dec;
        SP_INC:  sp <= sp + SPW'(1);
        default: sp <= sp;
      endcase
    end
  end

  AST_SP_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SP_DEC) |=> (sp == $past(sp) - SPW'(1))); // R4

  AST_SP_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SP_INC) |=> (sp == $past(sp) + SPW'(1))); // R7

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int DW = 16,
  parameter int SPW = 8,
  parameter int IE_BIT = 7,
  parameter logic [SPW-1:0] SP_RESET = 8'hF0,
  parameter logic [DW-1:0] VEC_BASE = 16'h0100,
  parameter int VEC_STRIDE = 16,
  localparam int SRCW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            instr_done,
  input  logic            iret,
  input  logic [DW-1:0]   next_pc,
  input  logic [DW-1:0]   psw_in,
  input  logic            vec_we,
  input  logic [SRCW-1:0] vec_sel,
  input  logic [DW-1:0]   vec_wdata,
  output logic [NSRC-1:0] irq_ack,
  output logic            stk_we,
  output logic            stk_re,
  output logic [SPW-1:0]  stk_addr,
  output logic [DW-1:0]   stk_wdata,
  input  logic [DW-1:0]   stk_rdata,
  output logic [SPW-1:0]  sp,
  output logic            pc_load,
  output logic [DW-1:0]   pc_load_val,
  output logic            psw_load,
  output logic [DW-1:0]   psw_load_val,
  output logic            fetch_redirect,
  output logic            busy
);

  localparam logic [DW-1:0] IE_MASK = DW'(1) << IE_BIT;

  seq_state_e      state_q, state_d;
  logic [SRCW-1:0] src_q;
  logic [DW-1:0]   ret_pc_q;
  logic [DW-1:0]   psw_q;
  logic [NSRC-1:0] pick_gnt;
  logic [SRCW-1:0] pick_idx;
  logic            pick_any;
  logic [DW-1:0]   vec_rdata;
  logic [SPW-1:0]  sp_dec;
  sp_op_e          sp_op;
  logic            take_irq;
  logic            take_ret;

  irq_prio_pick #(.N(NSRC)) u_pick (
    .req (irq_req),
    .gnt (pick_gnt),
    .idx (pick_idx),
    .any (pick_any)
  );

  irq_vec_bank #(
    .N          (NSRC),
    .DW         (DW),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_vec (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (vec_we),
    .wsel  (vec_sel),
    .wdata (vec_wdata),
    .rsel  (src_q),
    .rdata (vec_rdata)
  );

  irq_stack_ptr #(
    .SPW      (SPW),
    .SP_RESET (SP_RESET)
  ) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (sp_op),
    .sp     (sp),
    .sp_dec (sp_dec)
  );

  // Boundary decisions: return wins over a new request in the same cycle.
  assign take_ret = (state_q == ST_IDLE) && iret;
  assign take_irq = (state_q == ST_IDLE) && !iret && instr_done &&
                    psw_in[IE_BIT] && pick_any;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_ret) begin
          state_d = ST_POP_PSW;
        end else if (take_irq) begin
          state_d = ST_ACK;
        end
      end
      ST_ACK:      state_d = ST_PUSH_PC;
      ST_PUSH_PC:  state_d = ST_PUSH_PSW;
      ST_PUSH_PSW: state_d = ST_VECTOR;
      ST_VECTOR:   state_d = ST_IDLE;
      ST_POP_PSW:  state_d = ST_POP_PC;
      ST_POP_PC:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      src_q    <= '0;
      ret_pc_q <= '0;
      psw_q    <= '0;
    end else begin
      state_q <= state_d;
      if (take_irq) begin
        src_q    <= pick_idx;
        ret_pc_q <= next_pc;
        psw_q    <= psw_in;
      end else if (state_q == ST_POP_PSW) begin
        psw_q <= stk_rdata;
      end
    end
  end

  always_comb begin
    irq_ack        = '0;
    stk_we         = 1'b0;
    stk_re         = 1'b0;
    stk_addr       = sp;
    stk_wdata      = '0;
    pc_load        = 1'b0;
    pc_load_val    = '0;
    psw_load       = 1'b0;
    psw_load_val   = '0;
    fetch_redirect = 1'b0;
    sp_op          = SP_HOLD;
    unique case (state_q)
      ST_ACK: begin
        irq_ack[src_q] = 1'b1;
      end
      ST_PUSH_PC: begin
        stk_we    = 1'b1;
        stk_addr  = sp_dec;
        stk_wdata = ret_pc_q;
        sp_op     = SP_DEC;
      end
      ST_PUSH_PSW: begin
        stk_we    = 1'b1;
        stk_addr  = sp_dec;
        stk_wdata = psw_q;
        sp_op     = SP_DEC;
      end
      ST_VECTOR: begin
        pc_load        = 1'b1;
        pc_load_val    = vec_rdata;
        psw_load       = 1'b1;
        psw_load_val   = psw_q & ~IE_MASK;
        fetch_redirect = 1'b1;
      end
      ST_POP_PSW: begin
        stk_re = 1'b1;
        sp_op  = SP_INC;
      end
      ST_POP_PC: begin
        stk_re         = 1'b1;
        sp_op          = SP_INC;
        pc_load        = 1'b1;
        pc_load_val    = stk_rdata;
        psw_load       = 1'b1;
        psw_load_val   = psw_q;
        fetch_redirect = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack)); // R2

  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> $past(instr_done) && !$past(busy)); // R1

  AST_ACK_THEN_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |=> stk_we && !stk_re); // R4

  AST_STK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && stk_re)); // R4

  AST_REDIRECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_redirect |-> pc_load && psw_load); // R6

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_redirect |=> !busy); // R8

  AST_IRET_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && iret) |=> (irq_ack == '0) && stk_re); // R10

endmodule

// File: tb/irq_seq_tb_top.sv
module irq_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;
  localparam int DW = 16;
  localparam int SPW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic            instr_done = 1'b0;
  logic            iret = 1'b0;
  logic [DW-1:0]   next_pc = '0;
  logic [DW-1:0]   psw_in = '0;
  logic            vec_we = 1'b0;
  logic [1:0]      vec_sel = '0;
  logic [DW-1:0]   vec_wdata = '0;
  logic [NSRC-1:0] irq_ack;
  logic            stk_we, stk_re;
  logic [SPW-1:0]  stk_addr, sp;
  logic [DW-1:0]   stk_wdata, stk_rdata;
  logic            pc_load, psw_load, fetch_redirect, busy;
  logic [DW-1:0]   pc_load_val, psw_load_val;

  logic [DW-1:0] mem [256];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) if (stk_we) mem[stk_addr] <= stk_wdata;
  assign stk_rdata = mem[stk_addr];

  irq_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_done(instr_done),
    .iret(iret), .next_pc(next_pc), .psw_in(psw_in), .vec_we(vec_we),
    .vec_sel(vec_sel), .vec_wdata(vec_wdata), .irq_ack(irq_ack),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .sp(sp),
    .pc_load(pc_load), .pc_load_val(pc_load_val), .psw_load(psw_load),
    .psw_load_val(psw_load_val), .fetch_redirect(fetch_redirect), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Entry: boundary cycle, then ACK, PUSH_PC, PUSH_PSW, VECTOR, IDLE.
  task automatic run_entry(input logic [3:0] req, input logic [15:0] npc,
                           input logic [15:0] psw, input int src,
                           input logic [15:0] vec);
    logic [7:0] sp0;
    sp0 = sp;
    irq_req = req; next_pc = npc; psw_in = psw; instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    chk("R2 ack one-hot", 32'(irq_ack), 32'(4'b0001 << src));
    chk("R3 winner", 32'(irq_ack), 32'(4'b0001 << src));
    chk("R8 busy in ack", 32'(busy), 1);
    irq_req = irq_req & ~(4'b0001 << src);
    next_pc = 16'hDEAD; psw_in = 16'h0000;
    @(negedge clk);
    chk("R2 ack pulse ends", 32'(irq_ack), 0);
    chk("R4 push pc we", 32'(stk_we), 1);
    chk("R4 push pc addr", 32'(stk_addr), 32'(sp0 - 8'd1));
    chk("R5 saved next_pc", 32'(stk_wdata), 32'(npc));
    @(negedge clk);
    chk("R4 push psw addr", 32'(stk_addr), 32'(sp0 - 8'd2));
    chk("R5 saved psw", 32'(stk_wdata), 32'(psw));
    @(negedge clk);
    chk("R6 redirect", {29'd0, pc_load, psw_load, fetch_redirect}, 32'h7);
    chk("R6 vector", 32'(pc_load_val), 32'(vec));
    chk("R6 ie cleared", 32'(psw_load_val), 32'(psw & 16'hFF7F));
    @(negedge clk);
    chk("R8 busy drops", 32'(busy), 0);
    chk("R4 sp after entry", 32'(sp), 32'(sp0 - 8'd2));
    psw_in = psw & 16'hFF7F;
  endtask

  task automatic run_return(input logic [15:0] exp_pc, input logic [15:0] exp_psw,
                            input bit with_req);
    logic [7:0] sp0;
    sp0 = sp;
    iret = 1'b1;
    if (with_req) begin
      irq_req = 4'b0010; instr_done = 1'b1; psw_in = 16'h0080;
    end
    @(negedge clk);
    iret = 1'b0; instr_done = 1'b0;
    if (with_req) chk("R10 no ack on iret", 32'(irq_ack), 0);
    chk("R7 pop psw re", 32'(stk_re), 1);
    chk("R7 pop psw addr", 32'(stk_addr), 32'(sp0));
    @(negedge clk);
    chk("R7 pop pc addr", 32'(stk_addr), 32'(sp0 + 8'd1));
    chk("R7 redirect", {29'd0, pc_load, psw_load, fetch_redirect}, 32'h7);
    chk("R7 restored pc", 32'(pc_load_val), 32'(exp_pc));
    chk("R7 restored psw", 32'(psw_load_val), 32'(exp_psw));
    @(negedge clk);
    chk("R8 busy after return", 32'(busy), 0);
    chk("R7 sp after return", 32'(sp), 32'(sp0 + 8'd2));
    irq_req = '0;
    psw_in = exp_psw;
  endtask

  task automatic t_reset();
    chk("R12 busy", 32'(busy), 0);
    chk("R12 ack", 32'(irq_ack), 0);
    chk("R12 strobes", {28'd0, stk_we, stk_re, pc_load, fetch_redirect}, 0);
    chk("R12 sp", 32'(sp), 32'h00F0);
  endtask

  task automatic t_boundary_only();
    irq_req = 4'b0001; psw_in = 16'h0083;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 no ack mid-instruction", 32'(irq_ack), 0);
    end
    chk("R1 not busy", 32'(busy), 0);
    run_entry(4'b0001, 16'h1235, 16'h0083, 0, 16'h0100);
    run_return(16'h1235, 16'h0083, 0);
  endtask

  task automatic t_priority();
    run_entry(4'b1010, 16'h2001, 16'h0081, 1, 16'h0110);
    run_return(16'h2001, 16'h0081, 0);
  endtask

  task automatic t_vec_write();
    vec_we = 1'b1; vec_sel = 2'd3; vec_wdata = 16'h4ABC;
    @(negedge clk);
    vec_we = 1'b0;
    run_entry(4'b1000, 16'h3003, 16'h00C0, 3, 16'h4ABC);
    run_return(16'h3003, 16'h00C0, 0);
    run_entry(4'b0100, 16'h3100, 16'h0080, 2, 16'h0120); // R9 reset value of entry 2
    run_return(16'h3100, 16'h0080, 0);
  endtask

  task automatic t_masked();
    irq_req = 4'b0100; psw_in = 16'h0003;
    for (int i = 0; i < 3; i++) begin
      instr_done = 1'b1;
      @(negedge clk);
      chk("R11 masked no ack", 32'(irq_ack), 0);
      chk("R1 masked not busy", 32'(busy), 0);
    end
    instr_done = 1'b0;
    run_entry(4'b0100, 16'h0777, 16'h0083, 2, 16'h0120); // R11 taken once enabled
    run_return(16'h0777, 16'h0083, 0);
  endtask

  task automatic t_iret_priority();
    run_entry(4'b0001, 16'h5555, 16'h00A0, 0, 16'h0100);
    run_return(16'h5555, 16'h00A0, 1);
    @(negedge clk);
    chk("R10 idle after return", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boundary_only();
    t_priority();
    t_vec_write();
    t_masked();
    t_iret_priority();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule